// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block sits between a simple single-cycle request/acknowledge host port and an external asynchronous static RAM of 16-bit words with an 18-bit address. The RAM has active-low select, write strobe, output-enable and two byte-lane enables. The controller turns each accepted host request into a complete strobe sequence on the RAM pins. It counts system clock cycles so that every minimum interval of the RAM is met for the clock period given by `CLK_PERIOD_NS`. Each interval is rounded up to whole cycles, and every phase lasts at least one cycle.

The data bus is split into an outgoing value with its own drive enable and a separate incoming value, which the pad ring combines. Writes keep output-enable high for their whole length, so the RAM never drives the bus while the controller does. After every read, a release window with the RAM deselected and the controller's drivers off covers the RAM's output turn-off time. Between operations the RAM is always left deselected. Host byte enables select the lanes that are written or read: `be[0]` covers data bits 7:0 and `be[1]` covers bits 15:8. Read data lanes that were not requested return zero.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset and whenever no operation is in progress, the RAM is deselected: `sram_ce_n`, `sram_we_n`, `sram_oe_n`, `sram_lb_n` and `sram_ub_n` are 1 and `sram_dq_oe` is 0. While `sram_ce_n` is 1, both `sram_we_n` and `sram_oe_n` are 1.
- R2: A write starts with one setup cycle, in which select, address, lanes and data are applied while the write strobe is still high. The write strobe is then low for exactly WP cycles, where WP = ceil(35 ns / period), which is 5 at 8 ns.
- R3: Lane mapping: `be[0]`=1 drives `sram_lb_n` low, and that lane carries bits 7:0. `be[1]`=1 drives `sram_ub_n` low, and that lane carries bits 15:8. A write changes only the enabled lanes of the addressed word.
- R4: A read holds select and output-enable low, with the write strobe high, for RD cycles, where RD = ceil(45 ns / period), which is 6 at 8 ns. The captured word is presented on `rdata` in the cycle in which `ack` is high.
- R5: `sram_oe_n` is never low while `sram_we_n` is low, and the controller never drives the bus (`sram_dq_oe`=1) while `sram_oe_n` is low.
- R6: After a read, the RAM stays deselected and `sram_dq_oe` stays 0 for at least TA cycles, where TA = ceil(18 ns / period), which is 3 at 8 ns. No other access starts inside that window.
- R7: `ack` is high for exactly one cycle per accepted operation. A request raised while an operation is in progress is ignored: it causes no RAM access, no memory change and no `ack`.
- R8: From the first cycle with `sram_ce_n` low until the cycle it rises, the address, lane enables and written data do not change. This includes at least one hold cycle after the write strobe rises.
- R9: Each access keeps the RAM selected for at least ceil(45 ns / period) cycles, which is 6 at 8 ns.
- R10: A request with `be`=00 runs its full cycle with both lane enables high. A write of this kind changes no data, a read of this kind returns zero, and `ack` still pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Request; accepted only when idle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 18 | Word address |
| wdata | input | 16 | Write data |
| be | input | 2 | Byte enables, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read data, valid with ack |
| sram_addr | output | 18 | RAM address |
| sram_ce_n | output | 1 | RAM select, active low |
| sram_we_n | output | 1 | RAM write strobe, active low |
| sram_oe_n | output | 1 | RAM output enable, active low |
| sram_lb_n | output | 1 | Low lane enable, active low |
| sram_ub_n | output | 1 | High lane enable, active low |
| sram_dq_o | output | 16 | Data to the bus |
| sram_dq_oe | output | 1 | Drive enable for sram_dq_o |
| sram_dq_i | input | 16 | Data from the bus |

## Verification
The hardest situation to reach is a request that arrives in the middle of a write strobe or a read release window. A well-behaved host never produces it, because a host waits for `ack`. The bench therefore raises an intruding request with a different address a fixed number of cycles after an accepted one. It then checks that the per-cycle strobe trace is unchanged, that no extra `ack` appears, and that a later read of the intruder's address shows the old contents. A read followed immediately by a write is also issued, so the turnaround window and the bus-contention monitor are exercised at their tightest spacing.

// File: rtl/sram_ctrl_pkg.sv
// Package: shared state encoding and the nanosecond-to-cycle rounding
// used by the byte-lane SRAM controller.
// Assumes all timing inputs are non-negative integers in nanoseconds.
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WSETUP,
        ST_WPULSE,
        ST_WHOLD,
        ST_RACC,
        ST_RREL
    } ctl_state_t;

    // Round an interval up to whole clock cycles, never below one cycle.
    function automatic int ns_to_cycles(input int ns, input int period);
        int c;
        c = (ns + period - 1) / period;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
// Module: down-counter that measures the length of one strobe phase.
// Loaded with (cycles - 1) on phase entry; done is high in the last
// cycle of the phase. Assumes load values fit in CW bits.
module sram_phase_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);

    logic [CW-1:0] cnt_q;

    // Count down toward zero, reload at each phase start.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load)           cnt_q <= load_val;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_lane_map.sv
// Module: maps active-high host byte enables onto active-low RAM lane
// enables and zeroes the lanes of read data that were not requested.
// Assumes 8-bit lanes; lanes are deasserted whenever active is low.
module sram_lane_map #(
    parameter int LANES = 2
) (
    input  logic [LANES-1:0]   lane_req,
    input  logic               active,
    input  logic [LANES*8-1:0] rd_raw,
    output logic [LANES-1:0]   lane_n,
    output logic [LANES*8-1:0] rd_masked
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Lane strobe: low only during an access that asked for this lane.
        assign lane_n[g] = !(active && lane_req[g]);
        // Read path: pass the lane's byte or zero.
        assign rd_masked[g*8 +: 8] = lane_req[g] ? rd_raw[g*8 +: 8] : 8'h00;
    end

endmodule

// File: rtl/sram_async_ctrl.sv
// Module: synchronous controller for an asynchronous byte-lane SRAM.
// Accepts one request when idle, runs the write (setup, strobe, hold)
// or read (access, release) sequence with cycle counts derived from
// CLK_PERIOD_NS, and pulses ack at completion. Assumes the host holds
// request fields valid in the cycle req is high and waits for ack.
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int AW            = 18,
    parameter int DW            = 16,
    parameter int CLK_PERIOD_NS = 8,
    parameter int T_WC_NS       = 45,
    parameter int T_PWE_NS      = 35,
    parameter int T_RC_NS       = 45,
    parameter int T_AA_NS       = 45,
    parameter int T_DOE_NS      = 22,
    parameter int T_HZ_NS       = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [DW/8-1:0] be,
    output logic          ack,
    output logic [DW-1:0] rdata,
    output logic [AW-1:0] sram_addr,
    output logic          sram_ce_n,
    output logic          sram_we_n,
    output logic          sram_oe_n,
    output logic          sram_lb_n,
    output logic          sram_ub_n,
    output logic [DW-1:0] sram_dq_o,
    output logic          sram_dq_oe,
    input  logic [DW-1:0] sram_dq_i
);

    localparam int LANES  = DW / 8;
    localparam int WP_CYC = ns_to_cycles(T_PWE_NS, CLK_PERIOD_NS);
    localparam int WC_CYC = ns_to_cycles(T_WC_NS, CLK_PERIOD_NS);
    localparam int WH_CYC = max2(1, WC_CYC - 1 - WP_CYC);
    localparam int RD_CYC = max2(max2(ns_to_cycles(T_RC_NS, CLK_PERIOD_NS),
                                      ns_to_cycles(T_AA_NS, CLK_PERIOD_NS)),
                                 ns_to_cycles(T_DOE_NS, CLK_PERIOD_NS));
    localparam int TA_CYC = ns_to_cycles(T_HZ_NS, CLK_PERIOD_NS);
    localparam int MAXC   = max2(max2(WP_CYC, WH_CYC), max2(RD_CYC, TA_CYC));
    localparam int CW     = $clog2(MAXC + 1);

    localparam logic [CW-1:0] LD_ONE = '0;
    localparam logic [CW-1:0] LD_WP  = CW'(WP_CYC - 1);
    localparam logic [CW-1:0] LD_WH  = CW'(WH_CYC - 1);
    localparam logic [CW-1:0] LD_RD  = CW'(RD_CYC - 1);
    localparam logic [CW-1:0] LD_TA  = CW'(TA_CYC - 1);

    ctl_state_t       state_q, state_d;
    logic             tmr_load, tmr_done;
    logic [CW-1:0]    tmr_val;
    logic [AW-1:0]    addr_q;
    logic [DW-1:0]    wdata_q;
    logic [LANES-1:0] be_q;
    logic             ack_q, ack_d;
    logic [DW-1:0]    rdata_q, rd_masked;
    logic             access_on;
    logic [LANES-1:0] lane_n;

    sram_phase_timer #(.CW(CW)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    sram_lane_map #(.LANES(LANES)) lanes_i (
        .lane_req  (be_q),
        .active    (access_on),
        .rd_raw    (sram_dq_i),
        .lane_n    (lane_n),
        .rd_masked (rd_masked)
    );

    // Next-state, timer reload and completion decisions.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = LD_ONE;
        ack_d    = 1'b0;
        unique case (state_q)
            ST_IDLE: if (req) begin
                tmr_load = 1'b1;
                tmr_val  = we ? LD_ONE : LD_RD;
                state_d  = we ? ST_WSETUP : ST_RACC;
            end
            ST_WSETUP: if (tmr_done) begin
                tmr_load = 1'b1;
                tmr_val  = LD_WP;
                state_d  = ST_WPULSE;
            end
            ST_WPULSE: if (tmr_done) begin
                tmr_load = 1'b1;
                tmr_val  = LD_WH;
                state_d  = ST_WHOLD;
            end
            ST_WHOLD: if (tmr_done) begin
                ack_d   = 1'b1;
                state_d = ST_IDLE;
            end
            ST_RACC: if (tmr_done) begin
                ack_d    = 1'b1;
                tmr_load = 1'b1;
                tmr_val  = LD_TA;
                state_d  = ST_RREL;
            end
            ST_RREL: if (tmr_done) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State, completion pulse and request capture registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ack_q   <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            ack_q   <= ack_d;
            if (state_q == ST_IDLE && req) begin
                addr_q  <= addr;
                wdata_q <= wdata;
                be_q    <= be;
            end
            if (state_q == ST_RACC && tmr_done) rdata_q <= rd_masked;
        end
    end

    // Pin decode from the registered state.
    assign access_on  = (state_q == ST_WSETUP) || (state_q == ST_WPULSE) ||
                        (state_q == ST_WHOLD)  || (state_q == ST_RACC);
    assign sram_ce_n  = !access_on;
    assign sram_we_n  = (state_q != ST_WPULSE);
    assign sram_oe_n  = (state_q != ST_RACC);
    assign sram_dq_oe = (state_q == ST_WSETUP) || (state_q == ST_WPULSE) ||
                        (state_q == ST_WHOLD);
    assign sram_lb_n  = lane_n[0];
    assign sram_ub_n  = lane_n[LANES-1];
    assign sram_addr  = addr_q;
    assign sram_dq_o  = wdata_q;
    assign ack        = ack_q;
    assign rdata      = rdata_q;

endmodule

// File: rtl/sram_async_ctrl_chk.sv
// Module: protocol checker for the SRAM pins, bound into sram_async_ctrl.
// Assumes synchronous active-low reset; pulse widths use counters.
module sram_async_ctrl_chk #(
    parameter int AW     = 18,
    parameter int DW     = 16,
    parameter int WP_CYC = 5,
    parameter int TA_CYC = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ack,
    input logic [AW-1:0] sram_addr,
    input logic          sram_ce_n,
    input logic          sram_we_n,
    input logic          sram_oe_n,
    input logic          sram_lb_n,
    input logic          sram_ub_n,
    input logic [DW-1:0] sram_dq_o,
    input logic          sram_dq_oe
);

    logic [7:0] we_low_cnt;
    logic [7:0] oe_gap_cnt;

    // Length of the current write-strobe low run, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)          we_low_cnt <= '0;
        else if (!sram_we_n) we_low_cnt <= (we_low_cnt == 8'hFF) ? we_low_cnt : we_low_cnt + 1'b1;
        else                 we_low_cnt <= '0;
    end

    // Cycles since output-enable was last low, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)          oe_gap_cnt <= 8'hFF;
        else if (!sram_oe_n) oe_gap_cnt <= '0;
        else                 oe_gap_cnt <= (oe_gap_cnt == 8'hFF) ? oe_gap_cnt : oe_gap_cnt + 1'b1;
    end

    assert_deselect_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sram_ce_n |-> (sram_we_n && sram_oe_n));

    assert_we_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_we_n) |-> $past(!sram_ce_n));

    assert_we_pulse_min_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (we_low_cnt >= WP_CYC));

    assert_oe_off_in_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> sram_oe_n);

    assert_no_drive_in_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_oe_n |-> !sram_dq_oe);

    assert_turnaround_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_dq_oe) |-> (oe_gap_cnt >= TA_CYC));

    assert_ack_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    assert_addr_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_ce_n && $past(!sram_ce_n)) |->
            ($stable(sram_addr) && $stable(sram_lb_n) && $stable(sram_ub_n)));

    assert_wdata_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_dq_oe && $past(sram_dq_oe)) |-> $stable(sram_dq_o));

endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
    .AW(AW), .DW(DW), .WP_CYC(WP_CYC), .TA_CYC(TA_CYC)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ack        (ack),
    .sram_addr  (sram_addr),
    .sram_ce_n  (sram_ce_n),
    .sram_we_n  (sram_we_n),
    .sram_oe_n  (sram_oe_n),
    .sram_lb_n  (sram_lb_n),
    .sram_ub_n  (sram_ub_n),
    .sram_dq_o  (sram_dq_o),
    .sram_dq_oe (sram_dq_oe)
);

// File: tb/sram_async_ctrl_tb_top.sv
// Bench: behavioural byte-lane RAM, per-cycle expected pin trace held in
// a queue and compared at every falling clock edge, plus a contention monitor.
module sram_async_ctrl_tb_top;

    localparam int P = 8;

    function automatic int cyc(input int ns);
        int c;
        c = (ns + P - 1) / P;
        return (c < 1) ? 1 : c;
    endfunction

    localparam int E_WP = cyc(35);
    localparam int E_WC = cyc(45);
    localparam int E_WH = (E_WC - 1 - E_WP > 1) ? E_WC - 1 - E_WP : 1;
    localparam int E_RD = cyc(45);
    localparam int E_TA = cyc(18);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0, we = 1'b0;
    logic [17:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [1:0]  be = '0;
    logic ack;
    logic [15:0] rdata;
    logic [17:0] sram_addr;
    logic sram_ce_n, sram_we_n, sram_oe_n, sram_lb_n, sram_ub_n, sram_dq_oe;
    logic [15:0] sram_dq_o, sram_dq_i;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    sram_async_ctrl #(.CLK_PERIOD_NS(P)) dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
        .wdata(wdata), .be(be), .ack(ack), .rdata(rdata),
        .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n),
        .sram_oe_n(sram_oe_n), .sram_lb_n(sram_lb_n), .sram_ub_n(sram_ub_n),
        .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe), .sram_dq_i(sram_dq_i)
    );

    // Behavioural RAM and the bench's own shadow of expected contents.
    bit [15:0] ram    [int];
    bit [15:0] shadow [int];

    logic dev_drive;
    assign dev_drive = !sram_ce_n && !sram_oe_n && sram_we_n && !(sram_lb_n && sram_ub_n);
    always_comb begin
        sram_dq_i = 16'h5A5A;
        if (dev_drive) begin
            sram_dq_i[7:0]  = sram_lb_n ? 8'hEE : ram[int'(sram_addr)][7:0];
            sram_dq_i[15:8] = sram_ub_n ? 8'hEE : ram[int'(sram_addr)][15:8];
        end
    end

    // RAM write during the overlap of select, strobe and a lane.
    always @(negedge clk) begin
        if (rst_n && !sram_ce_n && !sram_we_n) begin
            bit [15:0] w;
            w = ram[int'(sram_addr)];
            if (!sram_lb_n) w[7:0]  = sram_dq_o[7:0];
            if (!sram_ub_n) w[15:8] = sram_dq_o[15:8];
            ram[int'(sram_addr)] = w;
        end
    end

    typedef struct {
        logic [6:0]  pins;   // ce, we, oe, lb, ub, dqoe, ack
        bit          ck_a;
        logic [17:0] a;
        bit          ck_w;
        logic [15:0] w;
        bit          ck_r;
        logic [15:0] r;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, expv, $time);
        end
    endtask

    function automatic exp_t mk(input logic [6:0] pins, input string tag);
        exp_t e;
        e.pins = pins; e.tag = tag;
        e.ck_a = 1'b0; e.a = '0; e.ck_w = 1'b0; e.w = '0; e.ck_r = 1'b0; e.r = '0;
        return e;
    endfunction

    localparam logic [6:0] IDLE_V = 7'b1111_100;

    // Per-cycle comparison against the expected trace (idle if queue empty).
    int ce_run = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            exp_t e;
            logic [6:0] act;
            act = {sram_ce_n, sram_we_n, sram_oe_n, sram_lb_n, sram_ub_n, sram_dq_oe, ack};
            if (exp_q.size() != 0) e = exp_q.pop_front();
            else                   e = mk(IDLE_V, "R1");
            check(act == e.pins, e.tag, "pins{ce,we,oe,lb,ub,dqoe,ack}", 32'(act), 32'(e.pins));
            if (e.ck_a) check(sram_addr == e.a, "R8", "sram_addr", 32'(sram_addr), 32'(e.a));
            if (e.ck_w) check(sram_dq_o == e.w, "R8", "sram_dq_o", 32'(sram_dq_o), 32'(e.w));
            if (e.ck_r) check(rdata == e.r, e.tag, "rdata", 32'(rdata), 32'(e.r));
            check(!(dev_drive && sram_dq_oe), "R5", "bus contention", 32'(sram_dq_oe), 32'(0));
            if (!sram_ce_n) ce_run++;
            else if (ce_run > 0) begin
                check(ce_run >= E_WC, "R9", "select length", 32'(ce_run), 32'(E_WC));
                ce_run = 0;
            end
        end
    end

    // Issue one operation, push its expected trace, optionally intrude.
    task automatic do_op(input bit w, input logic [17:0] a, input logic [15:0] d,
                         input logic [1:0] b, input int intr);
        exp_t e;
        logic lb, ub;
        string t;
        lb = !b[0]; ub = !b[1];
        t = (b == 2'b00) ? "R10" : "R3";
        @(negedge clk); #1;
        if (w) begin
            e = mk({1'b0, 1'b1, 1'b1, lb, ub, 1'b1, 1'b0}, "R2");
            e.ck_a = 1; e.a = a; e.ck_w = 1; e.w = d; exp_q.push_back(e);
            for (int i = 0; i < E_WP; i++) begin
                e = mk({1'b0, 1'b0, 1'b1, lb, ub, 1'b1, 1'b0}, (b == 0) ? t : "R2");
                e.ck_a = 1; e.a = a; e.ck_w = 1; e.w = d; exp_q.push_back(e);
            end
            for (int i = 0; i < E_WH; i++) begin
                e = mk({1'b0, 1'b1, 1'b1, lb, ub, 1'b1, 1'b0}, "R8");
                e.ck_a = 1; e.a = a; e.ck_w = 1; e.w = d; exp_q.push_back(e);
            end
            exp_q.push_back(mk(7'b1111_101, "R7"));
            if (b[0]) shadow[int'(a)][7:0]  = d[7:0];
            if (b[1]) shadow[int'(a)][15:8] = d[15:8];
        end else begin
            logic [15:0] r;
            r = shadow[int'(a)];
            if (!b[0]) r[7:0]  = 8'h00;
            if (!b[1]) r[15:8] = 8'h00;
            for (int i = 0; i < E_RD; i++) begin
                e = mk({1'b0, 1'b1, 1'b0, lb, ub, 1'b0, 1'b0}, "R4");
                e.ck_a = 1; e.a = a; exp_q.push_back(e);
            end
            e = mk(7'b1111_101, (b == 0) ? "R10" : "R4");
            e.ck_r = 1; e.r = r; exp_q.push_back(e);
            for (int i = 1; i < E_TA; i++) exp_q.push_back(mk(IDLE_V, "R6"));
            exp_q.push_back(mk(IDLE_V, "R6"));
        end
        req = 1; we = w; addr = a; wdata = d; be = b;
        @(negedge clk); #1;
        req = 0; addr = 18'h0; wdata = 16'h0; be = 2'b00;
        if (intr > 0) begin
            repeat (intr) @(negedge clk);
            #1;
            req = 1; we = 1; addr = 18'h0_0BAD; wdata = 16'hDEAD; be = 2'b11;
            @(negedge clk); #1;
            req = 0; addr = 18'h0; wdata = 16'h0; be = 2'b00;
        end
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state of every pin.
        check({sram_ce_n, sram_we_n, sram_oe_n, sram_lb_n, sram_ub_n, sram_dq_oe, ack} == IDLE_V,
              "R1", "reset pins", 32'({sram_ce_n, sram_we_n, sram_oe_n, sram_lb_n, sram_ub_n, sram_dq_oe, ack}),
              32'(IDLE_V));
        rst_n = 1;
        repeat (2) @(negedge clk);

        do_op(1, 18'h00010, 16'h1234, 2'b11, 0);
        do_op(0, 18'h00010, 16'h0000, 2'b11, 0);      // R4 full word
        do_op(1, 18'h00010, 16'hABCD, 2'b01, 0);      // R3 low lane only
        do_op(1, 18'h00010, 16'h5678, 2'b10, 0);      // R3 high lane only
        do_op(0, 18'h00010, 16'h0000, 2'b01, 0);
        do_op(0, 18'h00010, 16'h0000, 2'b10, 0);
        do_op(0, 18'h00010, 16'h0000, 2'b11, 0);
        check(ram[16] == 16'h56CD, "R3", "ram word", 32'(ram[16]), 32'h56CD);

        // R6: read immediately followed by a write.
        do_op(0, 18'h00010, 16'h0000, 2'b11, 0);
        do_op(1, 18'h00020, 16'h0F0F, 2'b11, 0);

        // R10: no lanes enabled.
        do_op(1, 18'h3FFFF, 16'hFFFF, 2'b00, 0);
        check(ram[int'(18'h3FFFF)] == 16'h0000, "R10", "ram unchanged", 32'(ram[int'(18'h3FFFF)]), 32'h0);
        do_op(0, 18'h3FFFF, 16'h0000, 2'b11, 0);
        do_op(0, 18'h00020, 16'h0000, 2'b00, 0);

        // R7: intruding requests during a write and during a read.
        do_op(1, 18'h00030, 16'hC0DE, 2'b11, 3);
        do_op(0, 18'h00030, 16'h0000, 2'b11, 3);
        do_op(0, 18'h00BAD, 16'h0000, 2'b11, 0);
        check(ram[int'(18'h00BAD)] == 16'h0000, "R7", "intruder left no data",
              32'(ram[int'(18'h00BAD)]), 32'h0);

        // Address patterns across the range.
        foreach (addr_list[i]) do_op(1, addr_list[i], 16'h1111 * 16'(i + 1) ^ 16'(addr_list[i]), 2'b11, 0);
        foreach (addr_list[i]) do_op(0, addr_list[i], 16'h0, 2'b11, 0);

        repeat (4) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    logic [17:0] addr_list [4] = '{18'h00000, 18'h3FFFF, 18'h2AAAA, 18'h15555};

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule